// File: doc/BRIEF.md
# Magnetic Cell Access Sequencer

This block turns single-cell requests from a host into the timed control levels that a one-transistor, one-junction magnetic memory row needs. A host presents a read or a write (with the data bit, a cell address and an optional verify flag) while the sequencer is idle. The sequencer then enables the word line and biases the bit line and select line for the operation. It times each phase with a programmable cycle count and returns a one-cycle response that carries a status code and the sensed bit.

The two write polarities are electrically opposite. Storing a 0 means forcing the junction into its low-resistance (parallel) state, which takes the bit line high and the select line low. Storing a 1 means forcing the high-resistance (antiparallel) state, which takes the select line high and the bit line low. The second polarity is the harder one, so each polarity has its own pulse length. An analog monitor reports through `cell_flip` that the junction has switched. A write pulse in which no switch is seen is reported as a timeout. After a successful write the cell can optionally be read back and compared with the written bit. Reads apply a small bias on the bit line with the select line grounded. The cell's state arrives on `cell_sense`.

Top module: `stt_cell_ctrl`

## Requirements
- R1: After reset, and whenever no operation is in progress, `cell_wl_en` is 0, `cell_bl` is 2'b00 (ground), `cell_sl` is 0, `resp_valid` is 0 and `req_ready` is 1.
- R2: A read holds `cell_wl_en`=1, `cell_bl`=2'b01 (read bias) and `cell_sl`=0 for exactly `cfg_rd_len` cycles, starting the cycle after acceptance. `resp_rdata` returns `cell_sense` as sampled in the last of those cycles, with status 2'b00.
- R3: A write of bit 0 holds `cell_wl_en`=1, `cell_bl`=2'b10 (high) and `cell_sl`=0 for exactly `cfg_w0_len` cycles.
- R4: A write of bit 1 holds `cell_wl_en`=1, `cell_bl`=2'b00 and `cell_sl`=1 for exactly `cfg_w1_len` cycles. `cell_bl`=2'b10 never coincides with `cell_sl`=1.
- R5: A programmed length of 0 for any phase behaves as a length of 1.
- R6: If `cell_flip` is low on every cycle of a write pulse, the pulse still runs its full length, no readback follows, and the status is 2'b01 (timeout).
- R7: A `cell_flip` seen on any pulse cycle, including the final one, makes the write succeed.
- R8: A successful write with `req_verify`=1 is followed by exactly one cycle with all lines grounded, then a read-bias phase of `cfg_rd_len` cycles. The status is 2'b10 if the sensed bit differs from the written bit, otherwise 2'b00, and `resp_rdata` carries the sensed bit.
- R9: Each operation ends with one cycle of `resp_valid`=1, during which all lines are grounded. `req_ready` returns the cycle after.
- R10: A request raised while `req_ready` is 0 is dropped and starts nothing. `cell_flip` outside a write pulse has no effect.
- R11: `cell_addr` equals the accepted `req_addr` on every cycle in which the word line is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 1 | Bit to store |
| req_verify | input | 1 | Read back and compare after a successful write |
| req_addr | input | ADDR_W | Cell address |
| req_ready | output | 1 | Sequencer idle |
| cfg_w0_len | input | CNT_W | Pulse length for writing 0, in cycles |
| cfg_w1_len | input | CNT_W | Pulse length for writing 1, in cycles |
| cfg_rd_len | input | CNT_W | Sense window length, in cycles |
| resp_valid | output | 1 | One-cycle completion strobe |
| resp_status | output | 2 | 00 ok, 01 write timeout, 10 verify mismatch |
| resp_rdata | output | 1 | Sensed bit |
| cell_wl_en | output | 1 | Word-line enable |
| cell_addr | output | ADDR_W | Address presented to the row decoders |
| cell_bl | output | 2 | Bit-line drive: 00 ground, 01 read bias, 10 high |
| cell_sl | output | 1 | Select-line drive: 0 ground, 1 high |
| cell_sense | input | 1 | Sense amplifier output |
| cell_flip | input | 1 | Switching detected on the cell |

## Verification
The two events that can meet in one cycle are the switch report and the deadline judgement. A `cell_flip` on the final pulse cycle arrives on the same clock edge at which the sequencer decides between timeout and success. The bench sweeps the flip position across the first cycle, the last cycle and just past the pulse, for both polarities and several lengths. A flip on the last cycle must yield success and, with verify on, a readback. A flip one cycle late must yield status 01 and no read-bias cycles.

// File: rtl/stt_ctrl_pkg.sv
package stt_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PULSE   = 3'd1,
        ST_GAP     = 3'd2,
        ST_SENSE   = 3'd3,
        ST_RECOVER = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        BL_GND  = 2'b00,
        BL_BIAS = 2'b01,
        BL_HIGH = 2'b10
    } bl_e;

    typedef enum logic [1:0] {
        RS_OK      = 2'b00,
        RS_TIMEOUT = 2'b01,
        RS_VERIFY  = 2'b10
    } resp_e;

    typedef struct packed {
        logic wl;
        bl_e  bl;
        logic sl;
    } line_t;

    localparam line_t LINES_DARK = '{wl: 1'b0, bl: BL_GND, sl: 1'b0};

    // Default phase lengths for a 1 GHz cell clock
    localparam int DEF_W0_LEN = 10;
    localparam int DEF_W1_LEN = 14;
    localparam int DEF_RD_LEN = 3;

    // Write polarity: bit 0 -> parallel (bit line high), bit 1 -> antiparallel (select line high)
    function automatic line_t write_bias(input logic bit_val);
        line_t l;
        l.wl = 1'b1;
        l.bl = bit_val ? BL_GND : BL_HIGH;
        l.sl = bit_val;
        return l;
    endfunction

endpackage

// File: rtl/stt_phase_timer.sv
module stt_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= (len == '0) ? '0 : len - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/stt_line_driver.sv
module stt_line_driver
    import stt_ctrl_pkg::*;
(
    input  phase_e phase,
    input  logic   wbit,
    output line_t  lines
);
    always_comb begin
        unique case (phase)
            ST_PULSE: lines = write_bias(wbit);
            ST_SENSE: lines = '{wl: 1'b1, bl: BL_BIAS, sl: 1'b0};
            default:  lines = LINES_DARK;
        endcase
    end
endmodule

// File: rtl/stt_switch_watch.sv
module stt_switch_watch (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic in_pulse,
    input  logic flip,
    output logic seen
);
    logic seen_q;
    logic hit;

    assign hit  = in_pulse & flip;
    assign seen = seen_q | hit;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            seen_q <= 1'b0;
        end else if (hit) begin
            seen_q <= 1'b1;
        end
    end
endmodule

// File: rtl/stt_cell_ctrl.sv
module stt_cell_ctrl
    import stt_ctrl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_wdata,
    input  logic              req_verify,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    input  logic [CNT_W-1:0]  cfg_w0_len,
    input  logic [CNT_W-1:0]  cfg_w1_len,
    input  logic [CNT_W-1:0]  cfg_rd_len,
    output logic              resp_valid,
    output logic [1:0]        resp_status,
    output logic              resp_rdata,
    output logic              cell_wl_en,
    output logic [ADDR_W-1:0] cell_addr,
    output logic [1:0]        cell_bl,
    output logic              cell_sl,
    input  logic              cell_sense,
    input  logic              cell_flip
);
    phase_e            phase_q, phase_d;
    logic              wbit_q, is_write_q, verify_q;
    logic [ADDR_W-1:0] addr_q;
    resp_e             status_q;
    logic              rdata_q;

    logic              accept;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_len;
    logic              tmr_last;
    logic              flip_seen;
    line_t             lines;

    assign accept = req_valid && (phase_q == ST_IDLE);

    stt_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load),
        .len  (tmr_len),
        .last (tmr_last)
    );

    stt_switch_watch u_watch (
        .clk      (clk),
        .rst      (rst),
        .clear    (accept),
        .in_pulse (phase_q == ST_PULSE),
        .flip     (cell_flip),
        .seen     (flip_seen)
    );

    stt_line_driver u_lines (
        .phase (phase_q),
        .wbit  (wbit_q),
        .lines (lines)
    );

    always_comb begin
        phase_d  = phase_q;
        tmr_load = 1'b0;
        tmr_len  = cfg_rd_len;
        unique case (phase_q)
            ST_IDLE: begin
                if (accept) begin
                    tmr_load = 1'b1;
                    if (req_write) begin
                        phase_d = ST_PULSE;
                        tmr_len = req_wdata ? cfg_w1_len : cfg_w0_len;
                    end else begin
                        phase_d = ST_SENSE;
                    end
                end
            end
            ST_PULSE: begin
                if (tmr_last) begin
                    phase_d = (flip_seen && verify_q) ? ST_GAP : ST_RECOVER;
                end
            end
            ST_GAP: begin
                tmr_load = 1'b1;
                phase_d  = ST_SENSE;
            end
            ST_SENSE: begin
                if (tmr_last) phase_d = ST_RECOVER;
            end
            default: phase_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= ST_IDLE;
            wbit_q     <= 1'b0;
            is_write_q <= 1'b0;
            verify_q   <= 1'b0;
            addr_q     <= '0;
            status_q   <= RS_OK;
            rdata_q    <= 1'b0;
        end else begin
            phase_q <= phase_d;
            if (accept) begin
                wbit_q     <= req_wdata;
                is_write_q <= req_write;
                verify_q   <= req_verify;
                addr_q     <= req_addr;
                status_q   <= RS_OK;
            end
            if (phase_q == ST_PULSE && tmr_last && !flip_seen) begin
                status_q <= RS_TIMEOUT;
            end
            if (phase_q == ST_SENSE && tmr_last) begin
                rdata_q <= cell_sense;
                if (is_write_q && (cell_sense != wbit_q)) status_q <= RS_VERIFY;
            end
        end
    end

    assign req_ready   = (phase_q == ST_IDLE);
    assign resp_valid  = (phase_q == ST_RECOVER);
    assign resp_status = status_q;
    assign resp_rdata  = rdata_q;
    assign cell_wl_en  = lines.wl;
    assign cell_bl     = lines.bl;
    assign cell_sl     = lines.sl;
    assign cell_addr   = addr_q;
endmodule

// File: rtl/stt_cell_ctrl_chk.sv
module stt_cell_ctrl_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              resp_valid,
    input logic              cell_wl_en,
    input logic [ADDR_W-1:0] cell_addr,
    input logic [1:0]        cell_bl,
    input logic              cell_sl
);
    assert_dark_lines_R1: assert property (@(posedge clk) disable iff (rst)
        !cell_wl_en |-> (cell_bl == 2'b00 && !cell_sl));

    assert_bias_sl_low_R2: assert property (@(posedge clk) disable iff (rst)
        cell_bl == 2'b01 |-> (!cell_sl && cell_wl_en));

    assert_no_contention_R4: assert property (@(posedge clk) disable iff (rst)
        !(cell_bl == 2'b10 && cell_sl));

    assert_start_after_accept_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (cell_wl_en && !req_ready));

    assert_resp_dark_R9: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> (!cell_wl_en && !req_ready));

    assert_resp_single_R9: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> (!resp_valid && req_ready && !cell_wl_en));

    assert_addr_stable_R11: assert property (@(posedge clk) disable iff (rst)
        (cell_wl_en && $past(cell_wl_en)) |-> $stable(cell_addr));
endmodule

bind stt_cell_ctrl stt_cell_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .cell_wl_en (cell_wl_en),
    .cell_addr  (cell_addr),
    .cell_bl    (cell_bl),
    .cell_sl    (cell_sl)
);

// File: tb/stt_cell_ctrl_tb.sv
`timescale 1ns/1ps
module stt_cell_ctrl_tb;
    localparam int ADDR_W = 8;
    localparam int CNT_W  = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0, req_write = 1'b0, req_wdata = 1'b0, req_verify = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_ready;
    logic [CNT_W-1:0]  cfg_w0_len = 8'd10, cfg_w1_len = 8'd14, cfg_rd_len = 8'd3;
    logic              resp_valid, resp_rdata;
    logic [1:0]        resp_status;
    logic              cell_wl_en, cell_sl;
    logic [ADDR_W-1:0] cell_addr;
    logic [1:0]        cell_bl;
    logic              cell_sense = 1'b0, cell_flip = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    stt_cell_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_wdata(req_wdata),
        .req_verify(req_verify), .req_addr(req_addr), .req_ready(req_ready),
        .cfg_w0_len(cfg_w0_len), .cfg_w1_len(cfg_w1_len), .cfg_rd_len(cfg_rd_len),
        .resp_valid(resp_valid), .resp_status(resp_status), .resp_rdata(resp_rdata),
        .cell_wl_en(cell_wl_en), .cell_addr(cell_addr), .cell_bl(cell_bl),
        .cell_sl(cell_sl), .cell_sense(cell_sense), .cell_flip(cell_flip)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clamp1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // One operation; flip_at = pulse-cycle index of the switch report, -1 for none
    task automatic run_op(input bit wr, input bit wb, input bit ver, input int flip_at,
                          input bit sense, input bit intrude, input bit stray_flip,
                          input logic [ADDR_W-1:0] adr);
        int plen, rlen, pulses, senses, dark_mid, exp_st, exp_senses;
        bit got, bad_pol, bad_addr, ok_flip;
        logic [1:0] st;
        logic rdv;
        string ptag;
        plen   = clamp1(wb ? int'(cfg_w1_len) : int'(cfg_w0_len));
        rlen   = clamp1(int'(cfg_rd_len));
        pulses = 0; senses = 0; dark_mid = 0;
        got = 0; bad_pol = 0; bad_addr = 0;
        st = 2'b11; rdv = 1'b0;
        ptag = wb ? "R4" : "R3";
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_wdata = wb; req_verify = ver;
        req_addr = adr; cell_sense = sense;
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = ~adr;
        for (int cyc = 0; cyc < 300; cyc++) begin
            req_valid = 1'b0;
            cell_flip = 1'b0;
            if (cell_wl_en && (cell_bl == 2'b10 || cell_sl)) begin
                if (wb ? !(cell_bl == 2'b00 && cell_sl) : !(cell_bl == 2'b10 && !cell_sl))
                    bad_pol = 1;
                cell_flip = (pulses == flip_at);
                pulses++;
                if (intrude && pulses == 2) begin
                    req_valid = 1'b1; req_write = 1'b0;
                end
            end else if (cell_wl_en && cell_bl == 2'b01) begin
                senses++;
                cell_flip = stray_flip;
            end else if (!cell_wl_en && pulses > 0 && senses == 0 && !resp_valid) begin
                dark_mid++;
                cell_flip = stray_flip;
            end
            if (cell_wl_en && cell_addr != adr) bad_addr = 1;
            if (resp_valid) begin
                got = 1; st = resp_status; rdv = resp_rdata;
                break;
            end
            @(negedge clk);
        end
        cell_flip = 1'b0;
        req_valid = 1'b0;
        chk(got, "R9", int'(got), 1);
        ok_flip = (flip_at >= 0) && (flip_at < plen);
        chk(!bad_addr, "R11", int'(bad_addr), 0);
        if (wr) begin
            chk(!bad_pol, ptag, int'(bad_pol), 0);
            if (wb) chk(pulses == plen, "R4", pulses, plen);
            else    chk(pulses == plen, "R3", pulses, plen);
            if ((wb ? cfg_w1_len : cfg_w0_len) == 0) chk(pulses == 1, "R5", pulses, 1);
            if (!ok_flip) begin
                chk(st == 2'b01, "R6", int'(st), 1);
                chk(senses == 0, "R6", senses, 0);
            end else begin
                exp_senses = ver ? rlen : 0;
                exp_st = (ver && sense != wb) ? 2 : 0;
                if (flip_at == plen - 1) chk(st != 2'b01, "R7", int'(st), exp_st);
                else chk(st == 2'(exp_st), "R7", int'(st), exp_st);
                if (ver) begin
                    chk(st == 2'(exp_st), "R8", int'(st), exp_st);
                    chk(senses == exp_senses, "R8", senses, exp_senses);
                    chk(dark_mid == 1, "R8", dark_mid, 1);
                    chk(rdv == sense, "R8", int'(rdv), int'(sense));
                end else begin
                    chk(senses == 0, "R7", senses, 0);
                end
            end
        end else begin
            chk(pulses == 0, "R2", pulses, 0);
            chk(senses == rlen, "R2", senses, rlen);
            if (cfg_rd_len == 0) chk(senses == 1, "R5", senses, 1);
            chk(st == 2'b00, stray_flip ? "R10" : "R2", int'(st), 0);
            chk(rdv == sense, stray_flip ? "R10" : "R2", int'(rdv), int'(sense));
        end
        @(negedge clk);
        chk(req_ready && !cell_wl_en && cell_bl == 2'b00 && !cell_sl, "R9",
            int'(req_ready), 1);
        if (intrude) begin
            repeat (2) begin
                @(negedge clk);
                chk(!cell_wl_en && !resp_valid && req_ready, "R10", int'(cell_wl_en), 0);
            end
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int lens[5];
        int fa[4];
        lens = '{0, 1, 3, 10, 14};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!cell_wl_en && cell_bl == 2'b00 && !cell_sl && req_ready && !resp_valid,
            "R1", int'(cell_wl_en), 0);

        // Defaults: 10 / 14 / 3
        run_op(1, 0, 1, 4, 0, 0, 0, 8'h21);
        run_op(1, 1, 1, 13, 1, 0, 0, 8'h42);
        run_op(0, 0, 0, -1, 1, 0, 0, 8'h07);

        // Write sweep: lengths, polarity, switch position, verify outcome
        foreach (lens[i]) begin
            cfg_w0_len = 8'(lens[i]);
            cfg_w1_len = 8'(lens[i] + 3);
            cfg_rd_len = 8'(1 + (i % 3));
            for (int wb = 0; wb < 2; wb++) begin
                int pl;
                pl = clamp1(wb ? lens[i] + 3 : lens[i]);
                fa = '{-1, 0, pl - 1, pl};
                foreach (fa[k]) begin
                    for (int v = 0; v < 2; v++) begin
                        for (int s = 0; s < 2; s++) begin
                            run_op(1, wb[0], v[0], fa[k], s[0], 0, 0, 8'(i * 16 + k * 4 + s));
                        end
                    end
                end
            end
        end

        // Read sweep, with stray switch reports that must be ignored
        for (int r = 0; r < 6; r++) begin
            cfg_rd_len = 8'(r);
            for (int s = 0; s < 2; s++) begin
                run_op(0, 0, 0, -1, s[0], 0, r[0], 8'(r * 2 + s));
            end
        end

        // Stray switch report in the gap before a verify read
        cfg_w0_len = 8'd4; cfg_w1_len = 8'd6; cfg_rd_len = 8'd2;
        run_op(1, 1, 1, 2, 1, 0, 1, 8'h99);

        // Request while busy must be dropped
        run_op(1, 0, 0, 1, 0, 1, 0, 8'h5a);
        run_op(1, 1, 1, 0, 0, 1, 0, 8'ha5);

        @(negedge clk);
        chk(!cell_wl_en && req_ready, "R1", int'(cell_wl_en), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule